// File: doc/BRIEF.md
# Dual-Converter ADC Scan Sequencer

This block sequences conversions for two converters that share an eight-way input multiplexer. A list of eight channel numbers sets the order of conversion. In sequential mode only converter A is used. It converts the first `listLen+1` list entries one after another. In simultaneous mode both converters run together on four pairs. Pair i converts entry i on converter A and entry i+4 on converter B. The two starts of a pair are issued in the same cycle, so the two entries of a pair must name different channels.

Each converter is driven through a start/done handshake and returns a 12-bit sample. The block subtracts a per-channel offset from the sample to form a signed 13-bit result. It stores that result in the buffer slot of its list position. It then tests the result against a shared low/high limit window. It also compares the sign with the previous sample of the same channel to detect zero crossings. When a scan ends, the block raises the enabled interrupts as one-cycle pulses.

A scan can run once and stop, run once per trigger, or repeat until a stop request arrives. A trigger that arrives while a scan is running does not start a scan and is flagged.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block is idle. `busy`, all interrupt pulses, both converter starts, `trigOvr`, `cfgErr`, `limHit` and `zcHit` are all 0.
- R2: In sequential mode (`simMode`=0), a scan starts converter A once for each list entry 0..`listLen`, in list order, with the channel taken from that entry. Converter B is never started.
- R3: In simultaneous mode (`simMode`=1), a scan runs exactly four pairs. Pair i starts A on entry i and B on entry i+4 in the same cycle. The next pair starts only after both converters have returned their done pulses.
- R4: In simultaneous mode, a scan whose list has entry i equal to entry i+4 for any i does not start and no converter is started. `cfgErr` goes to 1 and stays there until `clrFlags`. The same list is accepted in sequential mode.
- R5: The result stored for list slot s is (sample − offset[ch]) as a signed 13-bit value. The offset is `chanOffsets[12*ch +: 12]`. The result is read combinationally as `rdData` at `rdIdx`=s.
- R6: `limHit[s]` is set when the result of slot s is below `lowLim` or above `highLim`, both compared as signed values. All `limHit` bits are cleared when a scan starts.
- R7: The zero-crossing mode of channel ch is `zcMode[2*ch +: 2]`. Bit 0 enables a non-negative to negative change and bit 1 enables a negative to non-negative change, both relative to the previous sample of the same channel, including samples from earlier scans. The first sample of a channel after reset never flags a crossing. `zcHit[s]` records a crossing for slot s and is cleared at scan start.
- R8: In the cycle a scan ends, the block pulses `irqScan` if `irqEn[0]` is set. It pulses `irqLimit` if `irqEn[1]` is set and any `limHit` bit is set. It pulses `irqZc` if `irqEn[2]` is set and any `zcHit` bit is set.
- R9: With `scanMode`=0, a `startReq` pulse runs one scan. The block then returns to idle and starts nothing more.
- R10: With `scanMode`=1, `startReq` arms the block without converting. Each `trigIn` pulse while armed runs one scan and re-arms. `stopReq` while armed disarms, and later triggers then start nothing.
- R11: In `scanMode`=1, a `trigIn` that arrives while a scan is busy starts no extra scan. It sets `trigOvr`, which stays set until `clrFlags`.
- R12: With `scanMode`=2, scans repeat back to back until `stopReq`. The scan in progress then completes and no further scan starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanMode | input | 2 | 0 once, 1 triggered, 2 continuous |
| simMode | input | 1 | 0 sequential, 1 simultaneous pairs |
| listLen | input | 3 | Last list index used in sequential mode |
| chanList | input | 24 | Eight 3-bit channel numbers, entry k at bits 3k+2:3k |
| chanOffsets | input | 96 | Eight 12-bit per-channel offsets |
| lowLim | input | 13 | Signed low limit |
| highLim | input | 13 | Signed high limit |
| zcMode | input | 16 | Per-channel 2-bit zero-crossing mode |
| irqEn | input | 3 | Interrupt enables: scan, limit, zero crossing |
| startReq | input | 1 | Start pulse (once/continuous) or arm (triggered) |
| stopReq | input | 1 | Stop continuous scanning or disarm |
| trigIn | input | 1 | Scan trigger pulse |
| clrFlags | input | 1 | Clears `trigOvr` and `cfgErr` |
| convStartA | output | 1 | Start pulse to converter A |
| convChanA | output | 3 | Channel for converter A |
| convDoneA | input | 1 | Done pulse from converter A |
| convDataA | input | 12 | Sample from converter A |
| convStartB | output | 1 | Start pulse to converter B |
| convChanB | output | 3 | Channel for converter B |
| convDoneB | input | 1 | Done pulse from converter B |
| convDataB | input | 12 | Sample from converter B |
| rdIdx | input | 3 | Result buffer read slot |
| rdData | output | 13 | Signed result of slot `rdIdx` |
| limHit | output | 8 | Per-slot limit violation |
| zcHit | output | 8 | Per-slot zero crossing |
| busy | output | 1 | Scan in progress |
| irqScan | output | 1 | End-of-scan interrupt pulse |
| irqLimit | output | 1 | Limit interrupt pulse |
| irqZc | output | 1 | Zero-crossing interrupt pulse |
| trigOvr | output | 1 | Sticky trigger-overrun flag |
| cfgErr | output | 1 | Sticky illegal-pairing flag |

## Verification
The channel list is swept through every rotation in both conversion modes, with lengths 1 to 8 in sequential mode. This separates a design that honours list order and pairing from one that walks channels by index. Converter latencies vary with each scan, and B often finishes at a different time from A, which tests that both done pulses are joined before the next pair. Samples alternate in sign from scan to scan, which drives each zero-crossing direction and mode, the limit window, and the interrupt masks. Separate runs cover clashing pairs, overlapping triggers, disarming and a continuous run stopped mid-scan, to test which requests are refused.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CH_NUM   = 8;
  localparam int CH_W     = $clog2(CH_NUM);
  localparam int SMP_W    = 12;
  localparam int RES_W    = SMP_W + 1;
  localparam int SLOT_NUM = 8;
  localparam int SLOT_W   = $clog2(SLOT_NUM);
  localparam int HALF     = SLOT_NUM / 2;
  localparam int IRQ_NUM  = 3;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_TRIG = 2'd1,
    MODE_CONT = 2'd2
  } scanMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              clrHits;
    logic              capA;
    logic              capB;
    logic [CH_W-1:0]   chanA;
    logic [CH_W-1:0]   chanB;
    logic [SLOT_W-1:0] slotA;
    logic [SLOT_W-1:0] slotB;
    logic              scanEnd;
  } dpStrb_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               scanMode,
  input  logic                     simMode,
  input  logic [SLOT_W-1:0]        listLen,
  input  logic [SLOT_NUM*CH_W-1:0] chanList,
  input  logic                     startReq,
  input  logic                     stopReq,
  input  logic                     trigIn,
  input  logic                     clrFlags,
  input  logic                     convDoneA,
  input  logic                     convDoneB,
  output logic                     convStartA,
  output logic                     convStartB,
  output logic [CH_W-1:0]          convChanA,
  output logic [CH_W-1:0]          convChanB,
  output logic                     busy,
  output logic                     trigOvr,
  output logic                     cfgErr,
  output dpStrb_t                  strb
);
  typedef enum logic [2:0] {ST_IDLE, ST_ARM, ST_ISSUE, ST_WAIT, ST_END} st_e;

  st_e               state, stateNxt;
  logic [SLOT_W-1:0] idx, lastIdx, idxB;
  logic              gotA, gotB, stopPend;
  logic [CH_W-1:0]   listEnt [SLOT_NUM];
  logic              clash, pairClash;
  logic              isTrig, isCont;
  logic              launchReq, launchOk, pairDone;

  for (genvar g = 0; g < SLOT_NUM; g++) begin : g_unpack
    assign listEnt[g] = chanList[g*CH_W +: CH_W];
  end

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < HALF; i++)
      if (listEnt[i] == listEnt[i+HALF]) clash = 1'b1;
  end

  assign pairClash = simMode & clash;
  assign isTrig    = (scanMode == MODE_TRIG);
  assign isCont    = (scanMode == MODE_CONT);
  assign lastIdx   = simMode ? SLOT_W'(HALF-1) : listLen;
  assign idxB      = idx + SLOT_W'(HALF);
  assign busy      = (state == ST_ISSUE) || (state == ST_WAIT) || (state == ST_END);

  assign launchReq = ((state == ST_IDLE) && startReq && !isTrig)
                   || ((state == ST_ARM) && trigIn && !stopReq)
                   || ((state == ST_END) && isCont && !stopPend && !stopReq);
  assign launchOk  = launchReq && !pairClash;
  assign pairDone  = (state == ST_WAIT) && (gotA || convDoneA)
                   && (!simMode || gotB || convDoneB);

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  if (startReq && isTrig) stateNxt = ST_ARM;
      ST_ARM:   if (stopReq) stateNxt = ST_IDLE;
      ST_ISSUE: stateNxt = ST_WAIT;
      ST_WAIT:  if (pairDone) stateNxt = (idx == lastIdx) ? ST_END : ST_ISSUE;
      ST_END:   stateNxt = (isTrig && !stopPend && !stopReq) ? ST_ARM : ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
    if (launchReq) stateNxt = launchOk ? ST_ISSUE : ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      gotA     <= 1'b0;
      gotB     <= 1'b0;
      stopPend <= 1'b0;
      trigOvr  <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      state <= stateNxt;
      if (launchOk) idx <= '0;
      else if (pairDone && (idx != lastIdx)) idx <= idx + 1'b1;
      if (state == ST_ISSUE) begin
        gotA <= 1'b0;
        gotB <= 1'b0;
      end else if (state == ST_WAIT) begin
        gotA <= gotA | convDoneA;
        gotB <= gotB | convDoneB;
      end
      if ((stateNxt == ST_IDLE) || launchOk) stopPend <= 1'b0;
      else if (stopReq && busy) stopPend <= 1'b1;
      if (trigIn && isTrig && busy) trigOvr <= 1'b1;
      else if (clrFlags) trigOvr <= 1'b0;
      if (launchReq && pairClash) cfgErr <= 1'b1;
      else if (clrFlags) cfgErr <= 1'b0;
    end
  end

  assign convStartA = (state == ST_ISSUE);
  assign convStartB = (state == ST_ISSUE) && simMode;
  assign convChanA  = listEnt[idx];
  assign convChanB  = listEnt[idxB];

  always_comb begin
    strb.clrHits = launchOk;
    strb.capA    = (state == ST_WAIT) && convDoneA && !gotA;
    strb.capB    = (state == ST_WAIT) && simMode && convDoneB && !gotB;
    strb.chanA   = convChanA;
    strb.chanB   = convChanB;
    strb.slotA   = idx;
    strb.slotB   = idxB;
    strb.scanEnd = (state == ST_END);
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStartA |=> !convStartA); // R2
  AST_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
    convStartB |-> (convChanA != convChanB)); // R4
  AST_CLASH_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (launchReq && pairClash) |=> !busy); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (trigOvr && !clrFlags) |=> trigOvr); // R11
  AST_ONCE_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.scanEnd && (scanMode == MODE_ONCE)) |=> !busy); // R9
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.capA |-> (strb.slotA <= lastIdx)); // R2
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrb_t                    strb,
  input  logic [SMP_W-1:0]           convDataA,
  input  logic [SMP_W-1:0]           convDataB,
  input  logic [CH_NUM*SMP_W-1:0]    chanOffsets,
  input  logic [RES_W-1:0]           lowLim,
  input  logic [RES_W-1:0]           highLim,
  input  logic [2*CH_NUM-1:0]        zcMode,
  input  logic [IRQ_NUM-1:0]         irqEn,
  input  logic [SLOT_W-1:0]          rdIdx,
  output logic [RES_W-1:0]           rdData,
  output logic [SLOT_NUM-1:0]        limHit,
  output logic [SLOT_NUM-1:0]        zcHit,
  output logic                       irqScan,
  output logic                       irqLimit,
  output logic                       irqZc
);
  logic [RES_W-1:0] resBuf  [SLOT_NUM];
  logic             limHitR [SLOT_NUM];
  logic             zcHitR  [SLOT_NUM];
  logic             prevNeg   [CH_NUM];
  logic             prevValid [CH_NUM];
  logic [RES_W-1:0] resA, resB;
  logic             limA, limB, zcA, zcB;

  function automatic logic [RES_W-1:0] subOff(input logic [SMP_W-1:0] d,
                                              input logic [SMP_W-1:0] o);
    return {1'b0, d} - {1'b0, o};
  endfunction

  function automatic logic outside(input logic [RES_W-1:0] r,
                                   input logic [RES_W-1:0] lo,
                                   input logic [RES_W-1:0] hi);
    return ($signed(r) < $signed(lo)) || ($signed(r) > $signed(hi));
  endfunction

  function automatic logic crossed(input logic [RES_W-1:0] r, input logic pNeg,
                                   input logic pVal, input logic [1:0] m);
    logic neg;
    neg = r[RES_W-1];
    return pVal && ((m[0] && !pNeg && neg) || (m[1] && pNeg && !neg));
  endfunction

  assign resA = subOff(convDataA, chanOffsets[int'(strb.chanA)*SMP_W +: SMP_W]);
  assign resB = subOff(convDataB, chanOffsets[int'(strb.chanB)*SMP_W +: SMP_W]);
  assign limA = outside(resA, lowLim, highLim);
  assign limB = outside(resB, lowLim, highLim);
  assign zcA  = crossed(resA, prevNeg[strb.chanA], prevValid[strb.chanA],
                        zcMode[int'(strb.chanA)*2 +: 2]);
  assign zcB  = crossed(resB, prevNeg[strb.chanB], prevValid[strb.chanB],
                        zcMode[int'(strb.chanB)*2 +: 2]);

  for (genvar g = 0; g < SLOT_NUM; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        resBuf[g]  <= '0;
        limHitR[g] <= 1'b0;
        zcHitR[g]  <= 1'b0;
      end else begin
        if (strb.clrHits) begin
          limHitR[g] <= 1'b0;
          zcHitR[g]  <= 1'b0;
        end
        if (strb.capA && (strb.slotA == SLOT_W'(g))) begin
          resBuf[g]  <= resA;
          limHitR[g] <= limA;
          zcHitR[g]  <= zcA;
        end else if (strb.capB && (strb.slotB == SLOT_W'(g))) begin
          resBuf[g]  <= resB;
          limHitR[g] <= limB;
          zcHitR[g]  <= zcB;
        end
      end
    end
    assign limHit[g] = limHitR[g];
    assign zcHit[g]  = zcHitR[g];
  end

  for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevNeg[c]   <= 1'b0;
        prevValid[c] <= 1'b0;
      end else if (strb.capA && (strb.chanA == CH_W'(c))) begin
        prevNeg[c]   <= resA[RES_W-1];
        prevValid[c] <= 1'b1;
      end else if (strb.capB && (strb.chanB == CH_W'(c))) begin
        prevNeg[c]   <= resB[RES_W-1];
        prevValid[c] <= 1'b1;
      end
    end
  end

  assign rdData   = resBuf[rdIdx];
  assign irqScan  = strb.scanEnd && irqEn[0];
  assign irqLimit = strb.scanEnd && irqEn[1] && (|limHit);
  assign irqZc    = strb.scanEnd && irqEn[2] && (|zcHit);

  AST_HITS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrHits |=> ((limHit == '0) && (zcHit == '0))); // R6
  AST_CAP_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capA && strb.capB) |-> (strb.chanA != strb.chanB)); // R3
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 scanMode,
  input  logic                       simMode,
  input  logic [SLOT_W-1:0]          listLen,
  input  logic [SLOT_NUM*CH_W-1:0]   chanList,
  input  logic [CH_NUM*SMP_W-1:0]    chanOffsets,
  input  logic [RES_W-1:0]           lowLim,
  input  logic [RES_W-1:0]           highLim,
  input  logic [2*CH_NUM-1:0]        zcMode,
  input  logic [IRQ_NUM-1:0]         irqEn,
  input  logic                       startReq,
  input  logic                       stopReq,
  input  logic                       trigIn,
  input  logic                       clrFlags,
  output logic                       convStartA,
  output logic [CH_W-1:0]            convChanA,
  input  logic                       convDoneA,
  input  logic [SMP_W-1:0]           convDataA,
  output logic                       convStartB,
  output logic [CH_W-1:0]            convChanB,
  input  logic                       convDoneB,
  input  logic [SMP_W-1:0]           convDataB,
  input  logic [SLOT_W-1:0]          rdIdx,
  output logic [RES_W-1:0]           rdData,
  output logic [SLOT_NUM-1:0]        limHit,
  output logic [SLOT_NUM-1:0]        zcHit,
  output logic                       busy,
  output logic                       irqScan,
  output logic                       irqLimit,
  output logic                       irqZc,
  output logic                       trigOvr,
  output logic                       cfgErr
);
  dpStrb_t strb;

  adc_scan_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .scanMode(scanMode), .simMode(simMode),
    .listLen(listLen), .chanList(chanList), .startReq(startReq),
    .stopReq(stopReq), .trigIn(trigIn), .clrFlags(clrFlags),
    .convDoneA(convDoneA), .convDoneB(convDoneB),
    .convStartA(convStartA), .convStartB(convStartB),
    .convChanA(convChanA), .convChanB(convChanB),
    .busy(busy), .trigOvr(trigOvr), .cfgErr(cfgErr), .strb(strb)
  );

  adc_scan_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .convDataA(convDataA), .convDataB(convDataB),
    .chanOffsets(chanOffsets), .lowLim(lowLim), .highLim(highLim),
    .zcMode(zcMode), .irqEn(irqEn), .rdIdx(rdIdx), .rdData(rdData),
    .limHit(limHit), .zcHit(zcHit),
    .irqScan(irqScan), .irqLimit(irqLimit), .irqZc(irqZc)
  );
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  scanMode = 2'd0;
  logic        simMode = 1'b0;
  logic [2:0]  listLen = 3'd7;
  logic [23:0] chanList = '0;
  logic [95:0] chanOffsets = '0;
  logic [12:0] lowLim = '0, highLim = '0;
  logic [15:0] zcMode = '0;
  logic [2:0]  irqEn = 3'b111;
  logic        startReq = 0, stopReq = 0, trigIn = 0, clrFlags = 0;
  logic        convStartA, convStartB, convDoneA = 0, convDoneB = 0;
  logic [2:0]  convChanA, convChanB;
  logic [11:0] convDataA = '0, convDataB = '0;
  logic [2:0]  rdIdx = '0;
  logic [12:0] rdData;
  logic [7:0]  limHit, zcHit;
  logic        busy, irqScan, irqLimit, irqZc, trigOvr, cfgErr;

  adc_scan_seq dut_i (
    .clk(clk), .rstN(rstN), .scanMode(scanMode), .simMode(simMode),
    .listLen(listLen), .chanList(chanList), .chanOffsets(chanOffsets),
    .lowLim(lowLim), .highLim(highLim), .zcMode(zcMode), .irqEn(irqEn),
    .startReq(startReq), .stopReq(stopReq), .trigIn(trigIn), .clrFlags(clrFlags),
    .convStartA(convStartA), .convChanA(convChanA), .convDoneA(convDoneA),
    .convDataA(convDataA), .convStartB(convStartB), .convChanB(convChanB),
    .convDoneB(convDoneB), .convDataB(convDataB), .rdIdx(rdIdx), .rdData(rdData),
    .limHit(limHit), .zcHit(zcHit), .busy(busy), .irqScan(irqScan),
    .irqLimit(irqLimit), .irqZc(irqZc), .trigOvr(trigOvr), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int curPhase = 0;
  int listB [8];
  int expRes [8];
  bit expLim [8], expZc [8];
  bit prevNeg [8], prevValid [8];
  int startsA = 0, startsB = 0, pairMiss = 0;
  int cntScan = 0, cntLim = 0, cntZc = 0;
  bit lastLim = 0, lastZc = 0;
  bit pendA = 0, pendB = 0;
  int waitA = 0, waitB = 0;
  logic [2:0] chA = '0, chB = '0;
  bit finished = 0;

  function automatic int sampleOf(input int ch, input int ph);
    int mag;
    mag = 1 + 40*ch + 5*ph;
    return ((ph + ch) % 2 == 1) ? 2048 + mag : 2048 - mag;
  endfunction

  // converter models and event monitor, all on the falling edge
  always @(negedge clk) begin
    convDoneA <= 1'b0;
    convDoneB <= 1'b0;
    if (pendA) begin
      if (waitA == 0) begin
        convDoneA <= 1'b1; convDataA <= 12'(sampleOf(int'(chA), curPhase)); pendA <= 0;
      end else waitA <= waitA - 1;
    end
    if (pendB) begin
      if (waitB == 0) begin
        convDoneB <= 1'b1; convDataB <= 12'(sampleOf(int'(chB), curPhase)); pendB <= 0;
      end else waitB <= waitB - 1;
    end
    if (convStartA) begin
      pendA <= 1; chA <= convChanA; waitA <= curPhase % 3; startsA <= startsA + 1;
    end
    if (convStartB) begin
      pendB <= 1; chB <= convChanB; waitB <= (curPhase + 1) % 4; startsB <= startsB + 1;
    end
    if (convStartA && simMode && !convStartB) pairMiss <= pairMiss + 1;
    if (irqScan) begin
      cntScan <= cntScan + 1; lastLim <= irqLimit; lastZc <= irqZc;
    end
    if (irqLimit) cntLim <= cntLim + 1;
    if (irqZc) cntZc <= cntZc + 1;
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyList();
    for (int k = 0; k < 8; k++) chanList[k*3 +: 3] = 3'(listB[k]);
  endtask

  task automatic computeExp(input bit sim, input int len);
    int s, ch, r;
    bit neg, zc;
    for (int k = 0; k < 8; k++) begin expRes[k] = 0; expLim[k] = 0; expZc[k] = 0; end
    for (int k = 0; k < (sim ? 8 : len); k++) begin
      s  = sim ? ((k % 2 == 0) ? k/2 : k/2 + 4) : k;
      ch = listB[s];
      r  = sampleOf(ch, curPhase) - (2048 + 10*ch);
      neg = (r < 0);
      zc  = 0;
      if (prevValid[ch]) begin
        if (((ch % 4) & 1) != 0 && !prevNeg[ch] && neg) zc = 1;
        if (((ch % 4) & 2) != 0 && prevNeg[ch] && !neg) zc = 1;
      end
      expRes[s] = r;
      expLim[s] = (r < -150) || (r > 150);
      expZc[s]  = zc;
      prevNeg[ch] = neg;
      prevValid[ch] = 1;
    end
  endtask

  task automatic checkSlots(input bit sim, input int len);
    for (int s = 0; s < 8; s++) begin
      rdIdx = 3'(s);
      #1;
      if (sim || s < len) begin
        check(int'($signed(rdData)) == expRes[s], "R5 result", int'($signed(rdData)), expRes[s]);
        check(limHit[s] == expLim[s], "R6 limit", int'(limHit[s]), int'(expLim[s]));
        check(zcHit[s] == expZc[s], "R7 crossing", int'(zcHit[s]), int'(expZc[s]));
      end else begin
        check(limHit[s] == 1'b0, "R6 unused slot cleared", int'(limHit[s]), 0);
      end
    end
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    while (busy && n < 3000) begin tick(); n++; end
    check(!busy, "R9 scan completes", int'(busy), 0);
  endtask

  // one-shot scan with expected-value bookkeeping
  task automatic runOnce(input bit sim, input int len);
    int sA, sB, cS, cL, cZ;
    bit anyL, anyZ;
    curPhase++;
    simMode = sim; listLen = 3'(len - 1); scanMode = 2'd0;
    applyList();
    computeExp(sim, len);
    anyL = 0; anyZ = 0;
    for (int s = 0; s < 8; s++) begin anyL |= expLim[s]; anyZ |= expZc[s]; end
    sA = startsA; sB = startsB; cS = cntScan; cL = cntLim; cZ = cntZc;
    startReq = 1; tick(); startReq = 0;
    waitIdle();
    check(startsA - sA == (sim ? 4 : len), sim ? "R3 pair count" : "R2 A starts",
          startsA - sA, sim ? 4 : len);
    check(startsB - sB == (sim ? 4 : 0), sim ? "R3 B starts" : "R2 no B start",
          startsB - sB, sim ? 4 : 0);
    check(cntScan - cS == int'(irqEn[0]), "R8 scan irq", cntScan - cS, int'(irqEn[0]));
    check(cntLim - cL == int'(irqEn[1] && anyL), "R8 limit irq", cntLim - cL, int'(irqEn[1] && anyL));
    check(cntZc - cZ == int'(irqEn[2] && anyZ), "R8 zc irq", cntZc - cZ, int'(irqEn[2] && anyZ));
    checkSlots(sim, len);
    repeat (8) tick();
    check(!busy && startsA - sA == (sim ? 4 : len), "R9 halts after one scan",
          startsA - sA, sim ? 4 : len);
  endtask

  initial begin
    int sA, cS, n;
    for (int c = 0; c < 8; c++) begin
      chanOffsets[c*12 +: 12] = 12'(2048 + 10*c);
      zcMode[c*2 +: 2] = 2'(c % 4);
      prevNeg[c] = 0; prevValid[c] = 0;
    end
    lowLim = 13'h1FFF - 13'd149;
    highLim = 13'd150;
    repeat (3) tick();
    check(!busy && !convStartA && !convStartB, "R1 idle after reset", int'(busy), 0);
    check(!irqScan && !irqLimit && !irqZc, "R1 no irq", int'(irqScan), 0);
    check(!trigOvr && !cfgErr, "R1 flags clear", int'(trigOvr) + int'(cfgErr), 0);
    check(limHit == 8'h00 && zcHit == 8'h00, "R1 hits clear", int'(limHit), 0);
    rstN = 1; tick();

    // sequential sweep: every rotation of a permutation, every length
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 8; k++) listB[k] = (3*k + r) % 8;
      runOnce(1'b0, r + 1);
    end
    // sequential list with repeated channels
    listB = '{4, 4, 4, 6, 6, 1, 1, 1};
    runOnce(1'b0, 8);
    // simultaneous sweep
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 8; k++) listB[k] = (k + r) % 8;
      runOnce(1'b1, 8);
    end
    check(pairMiss == 0, "R3 same-cycle pair starts", pairMiss, 0);

    // illegal pairing
    listB = '{0, 1, 2, 3, 4, 5, 2, 7};
    applyList(); simMode = 1; scanMode = 2'd0;
    sA = startsA;
    startReq = 1; tick(); startReq = 0;
    repeat (5) tick();
    check(!busy && startsA == sA, "R4 clash refused", startsA - sA, 0);
    check(cfgErr, "R4 cfgErr set", int'(cfgErr), 1);
    repeat (3) tick();
    check(cfgErr, "R4 cfgErr sticky", int'(cfgErr), 1);
    clrFlags = 1; tick(); clrFlags = 0;
    check(!cfgErr, "R4 cfgErr cleared", int'(cfgErr), 0);
    runOnce(1'b0, 8);
    check(!cfgErr, "R4 legal in sequential", int'(cfgErr), 0);

    // interrupt masking
    for (int k = 0; k < 8; k++) listB[k] = 7 - k;
    irqEn = 3'b110; runOnce(1'b0, 8);
    irqEn = 3'b001; runOnce(1'b1, 8);
    irqEn = 3'b100; runOnce(1'b0, 5);
    irqEn = 3'b111;

    // triggered mode
    for (int k = 0; k < 8; k++) listB[k] = (5*k + 2) % 8;
    applyList(); simMode = 0; listLen = 3'd7; scanMode = 2'd1;
    sA = startsA;
    startReq = 1; tick(); startReq = 0;
    repeat (4) tick();
    check(!busy && startsA == sA, "R10 arm does not convert", startsA - sA, 0);
    for (int t = 0; t < 3; t++) begin
      curPhase++;
      computeExp(1'b0, 8);
      cS = cntScan;
      trigIn = 1; tick(); trigIn = 0;
      if (t == 1) begin
        repeat (3) tick();
        check(busy, "R11 busy before late trigger", int'(busy), 1);
        trigIn = 1; tick(); trigIn = 0;
      end
      waitIdle();
      check(cntScan - cS == 1, "R10 one scan per trigger", cntScan - cS, 1);
      checkSlots(1'b0, 8);
      repeat (6) tick();
      check(cntScan - cS == 1, "R11 no extra scan", cntScan - cS, 1);
      check(trigOvr == (t >= 1), "R11 overrun flag", int'(trigOvr), int'(t >= 1));
    end
    clrFlags = 1; tick(); clrFlags = 0;
    check(!trigOvr, "R11 overrun cleared", int'(trigOvr), 0);
    stopReq = 1; tick(); stopReq = 0;
    sA = startsA;
    trigIn = 1; tick(); trigIn = 0;
    repeat (6) tick();
    check(!busy && startsA == sA, "R10 disarmed ignores trigger", startsA - sA, 0);

    // continuous mode
    for (int k = 0; k < 8; k++) listB[k] = (k + 3) % 8;
    applyList(); simMode = 1; scanMode = 2'd2;
    curPhase++;
    computeExp(1'b1, 8);
    computeExp(1'b1, 8);
    sA = startsA; cS = cntScan;
    startReq = 1; tick(); startReq = 0;
    n = 0;
    while (cntScan - cS < 3 && n < 3000) begin tick(); n++; end
    repeat (4) tick();
    stopReq = 1; tick(); stopReq = 0;
    waitIdle();
    check(cntScan - cS >= 3, "R12 repeated scans", cntScan - cS, 3);
    check(startsA - sA == 4*(cntScan - cS), "R12 last scan completed", startsA - sA, 4*(cntScan - cS));
    checkSlots(1'b1, 8);
    cS = cntScan;
    repeat (30) tick();
    check(!busy && cntScan == cS, "R12 stopped", cntScan - cS, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule